// File: doc/BRIEF.md
# Byte-Stream Track Pattern Matcher

This block keeps a small bank of stored particle-track patterns and checks all of them at once against a stream of 8-bit symbols, taking one symbol per clock. Each pattern has three parts: an inclusive energy window, a calorimeter crystal address, and four 16-bit hit addresses, one for each detector layer from the innermost out. A stream starts with a header. In the full variant the header is an energy byte and then a crystal byte. After the header come hit addresses, grouped by layer from the innermost out. Each hit address is sent as two bytes, low byte first.

Every pattern is its own recogniser. It passes the header gates, then looks for its layer hits in order. It pulses one report bit when its outermost high byte arrives. Patterns come from a built-in default set after reset and can be replaced one at a time through a load port. A short variant, chosen by parameter, leaves out the energy byte.

The symbol input uses valid/ready. The block never applies back-pressure: `sym_ready` is high at all times. A symbol is accepted on every clock edge where `sym_valid` is high. Cycles with `sym_valid` low are gaps and change nothing. The start pulse and the load port are plain control pins.

Top module: `tpm_matcher`

## Requirements
- R1: In the full variant (HAS_ENERGY=1), accepted symbol 0 of a stream is the energy. A pattern can only proceed if e_min <= energy <= e_max, and both bounds are inclusive.
- R2: The crystal symbol must equal the pattern's crystal byte. This is symbol 1 in the full variant and symbol 0 in the short variant.
- R3: The hit region begins right after the header. Hit offsets count accepted symbols from the start of that region. A low-byte compare is only armed at even offsets. The high byte must be the very next accepted symbol, so a hit whose bytes are shifted by one symbol never matches.
- R4: Suppose a low byte matches but the next symbol is not the expected high byte. The search for that layer then starts again at the next even offset, and this repeats until the stream ends.
- R5: A pattern looks for the layer k+1 hit only after its layer k hit has matched. A hit for a later layer that arrives before an earlier layer has matched is ignored. Hits within one layer may come in any order.
- R6: rpt_mask[j] pulses high for exactly one cycle. That cycle follows the edge that accepted pattern j's layer-4 high byte, and in it sym_cnt equals that symbol's index plus one. Each pattern reports at most once per stream. A stream that ends before the layer-4 high byte gives no report.
- R7: All patterns evaluate the same symbol on the same edge. Several patterns may report in one stream, and they may report in the same cycle.
- R8: With HAS_ENERGY=0 the crystal is symbol 0 and the hit region starts at symbol 1. Reports therefore come one symbol earlier than in the full variant for the same hits.
- R9: A sym_sos pulse clears all pattern progress and resets sym_cnt. If sym_valid is high in the same cycle, that symbol becomes symbol 0 of the new stream.
- R10: sym_cnt is 0 after reset. It rises by one for each accepted symbol, holds during gaps, and saturates at 2^CNT_W-1.
- R11: Holding ld_en high for one edge writes ld_pat into slot ld_sel. The field layout is: bits [87:80] e_min, [79:72] e_max, [71:64] crystal, and bits [16k+15:16k] the hit for layer k+1 (k=0..3). After reset, slot j holds: e_min=16j, e_max=16j+40, crystal=0x30+j, and for layer k+1 a hit with high byte 0x10(k+1)+j and low byte 0x40+0x10k+j.
- R12: sym_ready is always high. No symbol is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_ready | output | 1 | Always high; no back-pressure |
| sym_data | input | 8 | Stream symbol |
| sym_sos | input | 1 | Start-of-stream pulse |
| ld_en | input | 1 | Pattern load strobe |
| ld_sel | input | SEL_W | Pattern slot to load |
| ld_pat | input | 88 | Pattern word (layout in R11) |
| rpt_mask | output | NPAT | One report pulse bit per pattern |
| sym_cnt | output | CNT_W | Count of accepted symbols in the current stream |

## Verification
The bench builds two instances that share the same inputs and patterns. The first is the full variant with four patterns and a 10-bit counter. The second is the short variant with four patterns and a 6-bit counter. Feeding one stream to both shows how the header gates differ and how reports shift one symbol earlier in the short variant. The 6-bit counter makes saturation reachable within a 90-symbol stream.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int LAYERS = 4;
  localparam int HIT_W  = 16;

  typedef struct packed {
    logic [7:0]                   e_min;
    logic [7:0]                   e_max;
    logic [7:0]                   crystal;
    logic [LAYERS-1:0][HIT_W-1:0] hit;
  } pat_t;

  localparam int PAT_W = $bits(pat_t);

  function automatic pat_t default_pat(input int j);
    pat_t p;
    p.e_min   = 8'(16 * j);
    p.e_max   = 8'(16 * j + 40);
    p.crystal = 8'(8'h30 + j);
    for (int k = 0; k < LAYERS; k++) begin
      p.hit[k] = {8'(16 * (k + 1) + j), 8'(8'h40 + 16 * k + j)};
    end
    return p;
  endfunction
endpackage

// File: rtl/tpm_seq.sv
module tpm_seq #(
  parameter int HAS_ENERGY = 1,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sos,
  input  logic             take,
  output logic [CNT_W-1:0] cnt,
  output logic             hdr_a,
  output logic             hdr_b,
  output logic             hit_sym,
  output logic             pair_lo
);
  localparam int HDR = (HAS_ENERGY != 0) ? 2 : 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, idx;
  logic             ph_q, ph;

  always_comb begin
    idx     = sos ? '0 : cnt_q;
    ph      = sos ? 1'b0 : ph_q;
    hdr_a   = take && (idx == '0);
    hdr_b   = take && (HAS_ENERGY != 0) && (idx == CNT_W'(1));
    hit_sym = take && (idx >= CNT_W'(HDR));
    pair_lo = !ph;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= take ? ((idx == CMAX) ? idx : idx + CNT_W'(1)) : idx;
      ph_q  <= hit_sym ? ~ph : ph;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tpm_store.sv
module tpm_store
  import tpm_pkg::*;
#(
  parameter int NPAT  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [PAT_W-1:0] ld_pat,
  output pat_t             pats [NPAT]
);
  for (genvar j = 0; j < NPAT; j++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pats[j] <= default_pat(j);
      end else if (ld_en && (ld_sel == SEL_W'(j))) begin
        pats[j] <= pat_t'(ld_pat);
      end
    end
  end
endmodule

// File: rtl/tpm_cell.sv
module tpm_cell
  import tpm_pkg::*;
#(
  parameter int HAS_ENERGY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       hdr_a,
  input  logic       hdr_b,
  input  logic       hit_sym,
  input  logic       pair_lo,
  input  logic [7:0] sym,
  input  pat_t       pat,
  output logic       rpt
);
  localparam int LW = $clog2(LAYERS);
  localparam logic [LW-1:0] LAST = LW'(LAYERS - 1);

  logic          gate_q, pend_q, done_q, rpt_q;
  logic [LW-1:0] lay_q;
  logic          gate_n, pend_n, done_n, rpt_n;
  logic [LW-1:0] lay_n;
  logic [HIT_W-1:0] want;

  always_comb begin
    gate_n = clr ? 1'b0 : gate_q;
    pend_n = clr ? 1'b0 : pend_q;
    done_n = clr ? 1'b0 : done_q;
    lay_n  = clr ? '0   : lay_q;
    rpt_n  = 1'b0;
    want   = pat.hit[lay_n];
    if (hdr_a) begin
      if (HAS_ENERGY != 0) gate_n = (sym >= pat.e_min) && (sym <= pat.e_max);
      else                 gate_n = (sym == pat.crystal);
    end
    if (hdr_b) gate_n = gate_n && (sym == pat.crystal);
    if (hit_sym && gate_n && !done_n) begin
      if (pend_n) begin
        pend_n = 1'b0;
        if (sym == want[15:8]) begin
          if (lay_n == LAST) begin
            done_n = 1'b1;
            rpt_n  = 1'b1;
          end else begin
            lay_n = lay_n + LW'(1);
          end
        end
      end else if (pair_lo && (sym == want[7:0])) begin
        pend_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      rpt_q  <= 1'b0;
      lay_q  <= '0;
    end else begin
      gate_q <= gate_n;
      pend_q <= pend_n;
      done_q <= done_n;
      rpt_q  <= rpt_n;
      lay_q  <= lay_n;
    end
  end

  assign rpt = rpt_q;
endmodule

// File: rtl/tpm_matcher.sv
module tpm_matcher
  import tpm_pkg::*;
#(
  parameter int NPAT       = 4,
  parameter int CNT_W      = 10,
  parameter int HAS_ENERGY = 1,
  localparam int SEL_W     = (NPAT > 1) ? $clog2(NPAT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [7:0]       sym_data,
  input  logic             sym_sos,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [PAT_W-1:0] ld_pat,
  output logic [NPAT-1:0]  rpt_mask,
  output logic [CNT_W-1:0] sym_cnt
);
  logic hdr_a, hdr_b, hit_sym, pair_lo;
  pat_t pats [NPAT];

  assign sym_ready = 1'b1;

  tpm_seq #(.HAS_ENERGY(HAS_ENERGY), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sos(sym_sos), .take(sym_valid),
    .cnt(sym_cnt), .hdr_a(hdr_a), .hdr_b(hdr_b),
    .hit_sym(hit_sym), .pair_lo(pair_lo)
  );

  tpm_store #(.NPAT(NPAT), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_pat(ld_pat), .pats(pats)
  );

  for (genvar j = 0; j < NPAT; j++) begin : g_cell
    tpm_cell #(.HAS_ENERGY(HAS_ENERGY)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(sym_sos),
      .hdr_a(hdr_a), .hdr_b(hdr_b), .hit_sym(hit_sym), .pair_lo(pair_lo),
      .sym(sym_data), .pat(pats[j]), .rpt(rpt_mask[j])
    );
  end
endmodule

// File: rtl/tpm_checker.sv
module tpm_checker #(
  parameter int NPAT       = 4,
  parameter int CNT_W      = 10,
  parameter int HAS_ENERGY = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_valid,
  input logic             sym_sos,
  input logic [NPAT-1:0]  rpt_mask,
  input logic [CNT_W-1:0] sym_cnt
);
  localparam int MIN_LEN = ((HAS_ENERGY != 0) ? 2 : 1) + 8;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [NPAT-1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else        seen <= sym_sos ? '0 : (seen | rpt_mask);
  end

  a_r6_once_per_stream: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_mask & seen) == '0);

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|rpt_mask) |=> ((rpt_mask & $past(rpt_mask)) == '0));

  a_r6_needs_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (|rpt_mask) |-> $past(sym_valid));

  a_r3_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    (|rpt_mask) |-> (sym_cnt >= CNT_W'(MIN_LEN)));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && !sym_sos && sym_cnt != CMAX) |=> (sym_cnt == $past(sym_cnt) + CNT_W'(1)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_valid && !sym_sos) |=> $stable(sym_cnt));

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sym_sos |=> (sym_cnt == CNT_W'($past(sym_valid))));
endmodule

bind tpm_matcher tpm_checker #(.NPAT(NPAT), .CNT_W(CNT_W), .HAS_ENERGY(HAS_ENERGY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_sos(sym_sos),
  .rpt_mask(rpt_mask), .sym_cnt(sym_cnt)
);

// File: tb/tb_tpm_matcher.sv
module tb_tpm_matcher;
  import tpm_pkg::*;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sym_valid, sym_sos, ld_en;
  logic [7:0] sym_data;
  logic [1:0] ld_sel;
  logic [PAT_W-1:0] ld_pat;
  logic rdy_a, rdy_b;
  logic [NP-1:0] rpt_a, rpt_b;
  logic [9:0] cnt_a;
  logic [5:0] cnt_b;

  tpm_matcher #(.NPAT(NP), .CNT_W(10), .HAS_ENERGY(1)) dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(rdy_a),
    .sym_data(sym_data), .sym_sos(sym_sos), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_pat(ld_pat), .rpt_mask(rpt_a), .sym_cnt(cnt_a));

  tpm_matcher #(.NPAT(NP), .CNT_W(6), .HAS_ENERGY(0)) dut_b (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(rdy_b),
    .sym_data(sym_data), .sym_sos(sym_sos), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_pat(ld_pat), .rpt_mask(rpt_b), .sym_cnt(cnt_b));

  int nchk = 0, nerr = 0;
  logic [7:0] stm [0:127];
  int len;
  pat_t pats [NP];
  int na [NP], ia [NP], nb [NP], ib [NP];

  always @(negedge clk) begin
    if (rst_n) begin
      for (int j = 0; j < NP; j++) begin
        if (rpt_a[j]) begin na[j]++; ia[j] = int'(cnt_a) - 1; end
        if (rpt_b[j]) begin nb[j]++; ib[j] = int'(cnt_b) - 1; end
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic pat_t dflt(input int j);
    pat_t p;
    p.e_min = 8'(16 * j); p.e_max = 8'(16 * j + 40); p.crystal = 8'(48 + j);
    for (int k = 0; k < 4; k++) p.hit[k] = {8'(16 * (k + 1) + j), 8'(64 + 16 * k + j)};
    return p;
  endfunction

  function automatic int ref_idx(input pat_t p, input bit has_e);
    int hdr; int lay; bit pend;
    hdr = has_e ? 2 : 1; lay = 0; pend = 1'b0;
    if (len < hdr) return -1;
    if (has_e) begin
      if (stm[0] < p.e_min || stm[0] > p.e_max || stm[1] != p.crystal) return -1;
    end else if (stm[0] != p.crystal) return -1;
    for (int i = hdr; i < len; i++) begin
      if (pend) begin
        pend = 1'b0;
        if (stm[i] == p.hit[lay][15:8]) begin
          if (lay == 3) return i;
          lay++;
        end
      end else if (((i - hdr) % 2 == 0) && stm[i] == p.hit[lay][7:0]) pend = 1'b1;
    end
    return -1;
  endfunction

  function automatic int seen_at(input int n, input int i);
    return (n == 0) ? -1 : ((n > 1) ? -2 : i);
  endfunction

  task automatic push(input logic [7:0] b);
    if (len < 128) begin stm[len] = b; len++; end
  endtask

  task automatic push_hit(input logic [15:0] h);
    push(h[7:0]); push(h[15:8]);
  endtask

  task automatic push_hdr(input pat_t p, input bit has_e, input logic [7:0] e);
    if (has_e) push(e);
    push(p.crystal);
  endtask

  task automatic push_layer(input pat_t p, input int k);
    int n; int pos;
    n = int'($urandom % 3); pos = int'($urandom % (n + 1));
    for (int i = 0; i <= n; i++) begin
      if (i == pos) push_hit(p.hit[k]);
      else push_hit(16'($urandom));
    end
  endtask

  task automatic build_good(input pat_t p, input bit has_e, input logic [7:0] e);
    len = 0;
    push_hdr(p, has_e, e);
    for (int k = 0; k < 4; k++) push_layer(p, k);
  endtask

  task automatic load(input int j, input pat_t p);
    ld_en = 1'b1; ld_sel = 2'(j); ld_pat = p; tick; ld_en = 1'b0;
    pats[j] = p;
  endtask

  task automatic run(input bit sos_first, input string req);
    int ea; int eb;
    for (int j = 0; j < NP; j++) begin na[j] = 0; nb[j] = 0; ia[j] = 0; ib[j] = 0; end
    if (!sos_first) begin sym_sos = 1'b1; sym_valid = 1'b0; tick; sym_sos = 1'b0; end
    for (int i = 0; i < len; i++) begin
      while ($urandom % 4 == 0) begin sym_valid = 1'b0; tick; end
      sym_valid = 1'b1; sym_data = stm[i]; sym_sos = (i == 0) && sos_first;
      tick;
      sym_sos = 1'b0;
    end
    sym_valid = 1'b0;
    repeat (3) tick;
    for (int j = 0; j < NP; j++) begin
      ea = ref_idx(pats[j], 1'b1);
      chk(seen_at(na[j], ia[j]) == ea, req, seen_at(na[j], ia[j]), ea);
      if (len <= 63) begin
        eb = ref_idx(pats[j], 1'b0);
        chk(seen_at(nb[j], ib[j]) == eb, req, seen_at(nb[j], ib[j]), eb);
      end
    end
    chk(int'(cnt_a) == len, "R10", int'(cnt_a), len);
    eb = (len > 63) ? 63 : len;
    chk(int'(cnt_b) == eb, "R10", int'(cnt_b), eb);
    chk(rdy_a && rdy_b, "R12", int'(rdy_a && rdy_b), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R6 watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    pat_t p;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sym_valid = 1'b0; sym_sos = 1'b0; sym_data = '0;
    ld_en = 1'b0; ld_sel = '0; ld_pat = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk(rpt_a == '0 && rpt_b == '0, "R6", int'(rpt_a), 0);
    chk(cnt_a == '0 && cnt_b == '0, "R10", int'(cnt_a), 0);
    chk(rdy_a && rdy_b, "R12", int'(rdy_a), 1);

    // R11: default pattern set after reset
    for (int j = 0; j < NP; j++) pats[j] = dflt(j);
    build_good(pats[1], 1'b1, 8'd20); run(1'b0, "R11");
    build_good(pats[2], 1'b0, 8'd0);  run(1'b1, "R11");

    // R11: load new patterns, shared crystal, overlapping energy windows
    for (int j = 0; j < NP; j++) begin
      p.e_min = 8'(60 + $urandom % 40);
      p.e_max = 8'(100 + $urandom % 60);
      p.crystal = 8'h5A;
      for (int k = 0; k < 4; k++) p.hit[k] = 16'($urandom);
      load(j, p);
    end
    build_good(pats[2], 1'b1, 8'd100); run(1'b1, "R11");

    // R1: inclusive energy window edges
    build_good(pats[0], 1'b1, pats[0].e_min);         run(1'b0, "R1");
    build_good(pats[0], 1'b1, pats[0].e_max);         run(1'b1, "R1");
    build_good(pats[0], 1'b1, pats[0].e_min - 8'd1);  run(1'b0, "R1");
    build_good(pats[0], 1'b1, pats[0].e_max + 8'd1);  run(1'b0, "R1");

    // R2: wrong crystal
    build_good(pats[1], 1'b1, 8'd100); stm[1] = stm[1] ^ 8'h01; run(1'b0, "R2");

    // R3: every hit shifted by one stray byte
    len = 0; push_hdr(pats[2], 1'b1, 8'd100); push(8'h77);
    for (int k = 0; k < 4; k++) push_hit(pats[2].hit[k]);
    run(1'b0, "R3");

    // R4: low byte matches, high byte wrong, then the correct pair
    len = 0; push_hdr(pats[3], 1'b1, 8'd100);
    push(pats[3].hit[0][7:0]); push(~pats[3].hit[0][15:8]);
    for (int k = 0; k < 4; k++) push_hit(pats[3].hit[k]);
    run(1'b1, "R4");

    // R5: layer 2 hit before layer 1
    len = 0; push_hdr(pats[1], 1'b1, 8'd100);
    push_hit(pats[1].hit[1]); push_hit(pats[1].hit[0]);
    push_hit(pats[1].hit[2]); push_hit(pats[1].hit[3]);
    run(1'b0, "R5");

    // R6: repeated outermost hit gives one report; truncated stream gives none
    build_good(pats[3], 1'b1, 8'd100); push_hit(pats[3].hit[3]); run(1'b0, "R6");
    build_good(pats[0], 1'b1, 8'd100); len--; run(1'b0, "R6");

    // R9: partial stream, then new stream with only the remaining layers
    len = 0; push_hdr(pats[0], 1'b1, 8'd100);
    push_hit(pats[0].hit[0]); push_hit(pats[0].hit[1]);
    run(1'b0, "R9");
    len = 0; push_hit(pats[0].hit[2]); push_hit(pats[0].hit[3]);
    run(1'b1, "R9");

    // R7: two patterns interleaved in one stream
    len = 0; push_hdr(pats[0], 1'b1, 8'd100);
    for (int k = 0; k < 4; k++) begin push_hit(pats[0].hit[k]); push_hit(pats[3].hit[k]); end
    run(1'b0, "R7");

    // R8: short variant header
    build_good(pats[1], 1'b0, 8'd0); run(1'b0, "R8");

    // R10: long stream saturates the narrow counter
    len = 0;
    for (int i = 0; i < 90; i++) push(8'($urandom));
    run(1'b0, "R10");

    // R7: random streams, both variants, some corrupted
    for (int it = 0; it < 40; it++) begin
      build_good(pats[$urandom % NP], (it % 2) == 0, 8'(50 + $urandom % 120));
      if ($urandom % 3 == 0) stm[$urandom % len] = 8'($urandom);
      run((it % 3) == 0, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule